// File: doc/BRIEF.md
# I2C Master Transmitter Byte Controller

This block lets a host send bytes on an I2C bus as the master transmitter. The host works through an 8-bit control register, an 8-bit data register and a read-only 8-bit status register. The control register requests START, repeated START and STOP conditions, and the data register holds the address byte or the data byte to send. Internally a bit engine drives the open-drain SCL and SDA lines. It shifts bytes out MSB first and samples the acknowledge on the ninth clock.

After each bus event the block writes a status code to the status register and sets the interrupt flag. While that flag is set, SCL is held low, so the bus stays frozen until software has read the status and cleared the flag. Bits 2:0 of the status register always read zero. This lets software use the status value directly as an offset into a jump table with eight-byte entries.

A bus monitor synchronises both lines. It detects START and STOP conditions made by any master and tracks whether the bus is busy, so that a START requested while another master owns the bus waits for the STOP. If the block releases SDA but sees it low while SCL is high, it has lost arbitration. It then lets go of both lines and reports the loss. A divider sets the quarter-bit period of SCL from the three clock-rate bits.

Top module: `i2c_mtx_ctrl`

## Requirements
- R1: After reset the control register reads 00h and the status register reads F8h. The control register reads back what was written, with bit 7 = rate bit 2, bit 6 = enable, bit 5 = START request, bit 4 = STOP request, bit 3 = interrupt flag, bit 2 = acknowledge enable (stored only), and bits 1:0 = rate bits 1:0.
- R2: While enable is 0, both line drivers are released, the STOP request and the interrupt flag read 0, and the status reads F8h. Writing enable = 0 clears the STOP request even when the same write sets it.
- R3: A START request on a free bus gives SDA falling while SCL is high. It then sets the interrupt flag with status 08h.
- R4: A START request made while the bus is busy (another master's START was seen) does not touch the bus until a STOP is seen. After that STOP the START is issued and status 08h is posted.
- R5: The address byte is sent MSB first. It posts 18h when the receiver acknowledges and 20h when it does not.
- R6: Each data byte is sent MSB first. It posts 28h when the receiver acknowledges and 30h when it does not.
- R7: While the interrupt flag is set, SCL is held low, except after an arbitration loss. The flag is cleared only by a register write with bit 3 = 0; writing 1 to bit 3 never sets it.
- R8: A START request made while the block is already master produces a repeated START and posts status 10h.
- R9: A STOP request in master mode gives SDA rising while SCL is high. The STOP request bit is cleared once that STOP is detected on the bus, the status returns to F8h, and the interrupt flag stays clear.
- R10: If SDA reads low while the block releases it during a data or address bit with SCL high, the block releases both lines, posts 38h and sets the interrupt flag.
- R11: Status bits 2:0 always read 0.
- R12: The irq output always equals the interrupt flag, bit 3 of the control register.
- R13: The quarter-bit period is BASE_DIV * 2^rate clock cycles, with rate = {bit 7, bit 1, bit 0}. With no clock stretching, one SCL period is four times this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| dat_wr | input | 1 | Write strobe for the data register |
| dat_wdata | input | 8 | Byte to transmit next |
| stat_rdata | output | 8 | Status code, bits 2:0 zero |
| irq | output | 1 | Interrupt request (interrupt flag) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The status code and the interrupt flag are written on the same clock edge, so the bench samples both at the first falling clock edge where irq reads high. At that point the scoreboard pops the expected code. A STOP reaches the STOP-request bit and the status only after the two-flop line synchroniser plus one detect cycle, and bus results take several quarter-bit ticks. For these the bench waits a fixed settle window well beyond that latency before sampling. Bit timing is measured between successive SCL rising edges in clock cycles.

// File: rtl/i2c_mtx_pkg.sv
package i2c_mtx_pkg;

  localparam int BYTE_BITS = 8;
  localparam int RATE_W    = 3;

  localparam int CB_CR2 = 7;
  localparam int CB_EN  = 6;
  localparam int CB_STA = 5;
  localparam int CB_STO = 4;
  localparam int CB_SI  = 3;
  localparam int CB_CR1 = 1;
  localparam int CB_CR0 = 0;

  localparam logic [4:0] SC_START   = 5'h01;
  localparam logic [4:0] SC_RSTART  = 5'h02;
  localparam logic [4:0] SC_ADR_ACK = 5'h03;
  localparam logic [4:0] SC_ADR_NAK = 5'h04;
  localparam logic [4:0] SC_DAT_ACK = 5'h05;
  localparam logic [4:0] SC_DAT_NAK = 5'h06;
  localparam logic [4:0] SC_ARB     = 5'h07;
  localparam logic [4:0] SC_IDLE    = 5'h1F;

  typedef enum logic [3:0] {
    ST_IDLE, ST_S_SDA, ST_S_SCL, ST_HOLD,
    ST_B0, ST_B1, ST_B2, ST_B3,
    ST_P1, ST_P2, ST_R1, ST_R2
  } eng_state_t;

endpackage

// File: rtl/i2c_mtx_rate.sv
module i2c_mtx_rate #(
  parameter int BASE_DIV = 4,
  parameter int RATE_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int MAX_DIV = BASE_DIV << ((1 << RATE_W) - 1);
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  assign lim  = CNT_W'((BASE_DIV << rate) - 1);
  assign tick = en && (cnt_q >= lim);

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_mtx_busmon.sv
module i2c_mtx_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic stop_det,
  output logic busy
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, busy_q, busy_d, start_det;

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign start_det = scl_s && scl_p && sda_p && !sda_s;
  assign stop_det  = scl_s && scl_p && !sda_p && sda_s;
  assign busy      = busy_q;

  always_comb begin
    busy_d = busy_q;
    if (!en)            busy_d = 1'b0;
    else if (start_det) busy_d = 1'b1;
    else if (stop_det)  busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/i2c_mtx_engine.sv
module i2c_mtx_engine
  import i2c_mtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       busy,
  input  logic       sta,
  input  logic       sto,
  input  logic       si,
  input  logic [7:0] tx_byte,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       ev_post,
  output logic       ev_irq,
  output logic [4:0] ev_code
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);

  eng_state_t state_q, state_d;
  logic [3:0] bcnt_q, bcnt_d;
  logic [7:0] shft_q, shft_d;
  logic scl_q, scl_d, sda_q, sda_d;
  logic adr_q, adr_d, rep_q, rep_d, ack_q, ack_d;

  assign scl_oe = scl_q;
  assign sda_oe = sda_q;

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    shft_d  = shft_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    adr_d   = adr_q;
    rep_d   = rep_q;
    ack_d   = ack_q;
    ev_post = 1'b0;
    ev_irq  = 1'b0;
    ev_code = SC_IDLE;
    if (!en) begin
      state_d = ST_IDLE;
      bcnt_d  = '0;
      scl_d   = 1'b0;
      sda_d   = 1'b0;
      adr_d   = 1'b0;
      rep_d   = 1'b0;
      ack_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          scl_d = 1'b0;
          sda_d = 1'b0;
          if (tick && sta && !si && !busy && scl_s && sda_s) begin
            sda_d   = 1'b1;
            rep_d   = 1'b0;
            state_d = ST_S_SDA;
          end
        end
        ST_S_SDA: if (tick) begin
          scl_d   = 1'b1;
          state_d = ST_S_SCL;
        end
        ST_S_SCL: if (tick) begin
          ev_post = 1'b1;
          ev_irq  = 1'b1;
          ev_code = rep_q ? SC_RSTART : SC_START;
          adr_d   = 1'b1;
          state_d = ST_HOLD;
        end
        ST_HOLD: if (tick && !si) begin
          if (sto) begin
            sda_d   = 1'b1;
            state_d = ST_P1;
          end else if (sta) begin
            sda_d   = 1'b0;
            state_d = ST_R1;
          end else begin
            shft_d  = tx_byte;
            bcnt_d  = '0;
            state_d = ST_B0;
          end
        end
        ST_B0: if (tick) begin
          sda_d   = (bcnt_q == LAST_BIT) ? 1'b0 : !shft_q[7];
          state_d = ST_B1;
        end
        ST_B1: if (tick) begin
          scl_d   = 1'b0;
          state_d = ST_B2;
        end
        ST_B2: if (tick && scl_s) begin
          if (bcnt_q != LAST_BIT) begin
            if (!sda_q && !sda_s) begin
              scl_d   = 1'b0;
              sda_d   = 1'b0;
              adr_d   = 1'b0;
              ev_post = 1'b1;
              ev_irq  = 1'b1;
              ev_code = SC_ARB;
              state_d = ST_IDLE;
            end else begin
              shft_d  = {shft_q[6:0], 1'b0};
              state_d = ST_B3;
            end
          end else begin
            ack_d   = !sda_s;
            state_d = ST_B3;
          end
        end
        ST_B3: if (tick) begin
          scl_d = 1'b1;
          if (bcnt_q == LAST_BIT) begin
            ev_post = 1'b1;
            ev_irq  = 1'b1;
            if (adr_q) ev_code = ack_q ? SC_ADR_ACK : SC_ADR_NAK;
            else       ev_code = ack_q ? SC_DAT_ACK : SC_DAT_NAK;
            adr_d   = 1'b0;
            state_d = ST_HOLD;
          end else begin
            bcnt_d  = bcnt_q + 1'b1;
            state_d = ST_B0;
          end
        end
        ST_P1: if (tick) begin
          scl_d   = 1'b0;
          state_d = ST_P2;
        end
        ST_P2: if (tick && scl_s) begin
          sda_d   = 1'b0;
          ev_post = 1'b1;
          ev_code = SC_IDLE;
          state_d = ST_IDLE;
        end
        ST_R1: if (tick) begin
          scl_d   = 1'b0;
          state_d = ST_R2;
        end
        ST_R2: if (tick && scl_s) begin
          sda_d   = 1'b1;
          rep_d   = 1'b1;
          state_d = ST_S_SDA;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      shft_q  <= '0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      adr_q   <= 1'b0;
      rep_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      shft_q  <= shft_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      adr_q   <= adr_d;
      rep_q   <= rep_d;
      ack_q   <= ack_d;
    end
  end
endmodule

// File: rtl/i2c_mtx_ctrl.sv
module i2c_mtx_ctrl
  import i2c_mtx_pkg::*;
#(
  parameter int BASE_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       dat_wr,
  input  logic [7:0] dat_wdata,
  output logic [7:0] stat_rdata,
  output logic       irq,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic [1:0] rst_sh;
  logic       rst_int_n;
  logic [7:0] ctl_q, ctl_d, dat_q;
  logic [4:0] code_q, code_d;
  logic tick, scl_s, sda_s, stop_det, busy;
  logic ev_post, ev_irq;
  logic [4:0] ev_code;
  logic [RATE_W-1:0] rate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_int_n = rst_sh[1];

  assign rate       = {ctl_q[CB_CR2], ctl_q[CB_CR1], ctl_q[CB_CR0]};
  assign ctl_rdata  = ctl_q;
  assign stat_rdata = {code_q, 3'b000};
  assign irq        = ctl_q[CB_SI];

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) begin
      ctl_d        = ctl_wdata;
      ctl_d[CB_SI] = ctl_q[CB_SI] & ctl_wdata[CB_SI];
    end
    if (ev_irq)   ctl_d[CB_SI]  = 1'b1;
    if (stop_det) ctl_d[CB_STO] = 1'b0;
    if (!ctl_d[CB_EN]) begin
      ctl_d[CB_STO] = 1'b0;
      ctl_d[CB_SI]  = 1'b0;
    end
  end

  always_comb begin
    code_d = code_q;
    if (ev_post)       code_d = ev_code;
    if (!ctl_d[CB_EN]) code_d = SC_IDLE;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctl_q  <= '0;
      code_q <= SC_IDLE;
      dat_q  <= '0;
    end else begin
      ctl_q  <= ctl_d;
      code_q <= code_d;
      if (dat_wr) dat_q <= dat_wdata;
    end
  end

  i2c_mtx_rate #(.BASE_DIV(BASE_DIV), .RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_int_n), .en(ctl_q[CB_EN]), .rate(rate), .tick(tick)
  );

  i2c_mtx_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_int_n), .en(ctl_q[CB_EN]),
    .scl_i(scl_i), .sda_i(sda_i), .scl_s(scl_s), .sda_s(sda_s),
    .stop_det(stop_det), .busy(busy)
  );

  i2c_mtx_engine u_eng (
    .clk(clk), .rst_n(rst_int_n), .en(ctl_q[CB_EN]), .tick(tick),
    .scl_s(scl_s), .sda_s(sda_s), .busy(busy),
    .sta(ctl_q[CB_STA]), .sto(ctl_q[CB_STO]), .si(ctl_q[CB_SI]),
    .tx_byte(dat_q), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ev_post(ev_post), .ev_irq(ev_irq), .ev_code(ev_code)
  );
endmodule

// File: rtl/i2c_mtx_ctrl_chk.sv
module i2c_mtx_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [7:0] ctl_rdata,
  input logic [7:0] stat_rdata,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe
);
  // R2: disabled interface shows cleared STOP request, flag and idle status
  p_off_regs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[6] |-> (ctl_rdata[4:3] == 2'b00 && stat_rdata == 8'hF8));

  // R2: lines released one cycle after the enable reads 0
  p_off_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[6] |=> (!scl_oe && !sda_oe));

  // R7: SCL held low while the flag is set, unless arbitration was lost
  p_scl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && stat_rdata != 8'h38) |-> scl_oe);

  // R7: the flag only falls after a control write
  p_si_sw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(ctl_wr));

  // R10: after arbitration loss both lines are free
  p_arb_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && stat_rdata == 8'h38) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_mtx_ctrl i2c_mtx_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rdata(ctl_rdata),
  .stat_rdata(stat_rdata), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_mtx_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_mtx_ctrl_tb;
  localparam logic [6:0] SLV_ADR = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0, dat_wr = 1'b0;
  logic [7:0] ctl_wdata = '0, dat_wdata = '0;
  logic [7:0] ctl_rdata, stat_rdata;
  logic irq, scl_oe, sda_oe;
  logic slv_low = 1'b0, force_sda = 1'b0, ack_data = 1'b1;
  wire scl_bus = ~scl_oe;
  wire sda_bus = ~(sda_oe | slv_low | force_sda);

  int tests = 0, fails = 0, cyc = 0;
  logic [7:0] exp_q[$];
  logic irq_seen = 1'b0;
  logic mon_on = 1'b0;
  logic done = 1'b0;

  // behavioural slave state
  logic scl_p = 1'b1, sda_p = 1'b1;
  int bcnt = 0, per = 0, last_rise = 0;
  logic [7:0] sh = '0, last_byte = '0;
  logic first = 1'b0, sel = 1'b0, ackd = 1'b0;
  logic saw_start = 1'b0, saw_stop = 1'b0;

  always #2.5 clk = ~clk;

  i2c_mtx_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .stat_rdata(stat_rdata), .irq(irq), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always @(posedge clk) cyc++;

  always begin
    @(scl_bus or sda_bus);
    if (scl_bus && scl_p && sda_p && !sda_bus) begin
      bcnt = 0; first = 1'b1; sel = 1'b0; slv_low = 1'b0; ackd = 1'b0;
      saw_start = 1'b1;
    end else if (scl_bus && scl_p && !sda_p && sda_bus) begin
      bcnt = 0; sel = 1'b0; slv_low = 1'b0; ackd = 1'b0;
      saw_stop = 1'b1;
    end else if (scl_bus && !scl_p) begin
      per = cyc - last_rise;
      last_rise = cyc;
      if (bcnt < 8) begin
        sh = {sh[6:0], sda_bus};
        bcnt++;
      end
    end else if (!scl_bus && scl_p) begin
      if (ackd) begin
        slv_low = 1'b0; ackd = 1'b0; bcnt = 0; first = 1'b0;
      end else if (bcnt == 8) begin
        last_byte = sh;
        if (first) sel = (sh[7:1] == SLV_ADR) && !sh[0];
        slv_low = first ? sel : (sel && ack_data);
        ackd = 1'b1;
      end
    end
    scl_p = scl_bus;
    sda_p = sda_bus;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one expected status per rising interrupt
  always @(negedge clk) begin
    if (mon_on && irq && !irq_seen) begin
      if (exp_q.size() == 0) chk(1'b0, "status seq R3 R5 R6 R8 R10 unexpected irq", stat_rdata, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(stat_rdata == e, "status seq R3 R5 R6 R8 R10", stat_rdata, e);
      end
      chk(stat_rdata[2:0] == 3'b000, "R11 low status bits", stat_rdata[2:0], 0);
    end
    irq_seen = irq;
  end

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 4000) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(irq == 1'b1, tag, irq, 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int held;
    idle(5); rst_n = 1'b1; idle(5);
    mon_on = 1'b1;
    chk(ctl_rdata == 8'h00, "R1 reset control", ctl_rdata, 8'h00);
    chk(stat_rdata == 8'hF8, "R1 reset status", stat_rdata, 8'hF8);
    chk(!scl_oe && !sda_oe, "R2 lines free at reset", {scl_oe, sda_oe}, 0);

    wr_ctl(8'h44);
    chk(ctl_rdata == 8'h44, "R1 readback", ctl_rdata, 8'h44);

    // START on a free bus
    wr_dat(8'hA0);
    saw_start = 1'b0;
    exp_q.push_back(8'h08);
    wr_ctl(8'h64);
    wait_irq("R3 irq after START");
    chk(saw_start, "R3 START on bus", saw_start, 1);
    chk(irq == ctl_rdata[3], "R12 irq follows flag", irq, ctl_rdata[3]);
    held = 0;
    repeat (60) begin @(negedge clk); if (scl_bus) held++; end
    chk(held == 0, "R7 SCL low while flag set", held, 0);

    // address byte, acknowledged
    exp_q.push_back(8'h18);
    wr_ctl(8'h44);
    wait_irq("R5 irq after address");
    chk(last_byte == 8'hA0, "R5 address bits MSB first", last_byte, 8'hA0);

    // data byte acknowledged, rate 0
    wr_dat(8'h3C);
    exp_q.push_back(8'h28);
    wr_ctl(8'h44);
    wait_irq("R6 irq after data ack");
    chk(last_byte == 8'h3C, "R6 data bits", last_byte, 8'h3C);
    chk(per == 16, "R13 SCL period rate 0", per, 16);

    // data byte not acknowledged, rate 1
    ack_data = 1'b0;
    wr_dat(8'hFF);
    exp_q.push_back(8'h30);
    wr_ctl(8'h45);
    wait_irq("R6 irq after data nack");
    chk(per == 32, "R13 SCL period rate 1", per, 32);
    ack_data = 1'b1;

    // repeated START, then a non-matching address
    saw_start = 1'b0;
    exp_q.push_back(8'h10);
    wr_ctl(8'h64);
    wait_irq("R8 irq after repeated START");
    chk(saw_start, "R8 repeated START on bus", saw_start, 1);
    wr_dat(8'hA2);
    exp_q.push_back(8'h20);
    wr_ctl(8'h44);
    wait_irq("R5 irq after address nack");

    // STOP
    saw_stop = 1'b0;
    wr_ctl(8'h54);
    idle(200);
    chk(saw_stop, "R9 STOP on bus", saw_stop, 1);
    chk(ctl_rdata == 8'h44, "R9 STOP request cleared", ctl_rdata, 8'h44);
    chk(stat_rdata == 8'hF8, "R9 status idle", stat_rdata, 8'hF8);
    chk(!irq && !scl_oe && !sda_oe, "R9 flag clear, lines free", {irq, scl_oe, sda_oe}, 0);

    // another master holds the bus
    force_sda = 1'b1;
    idle(20);
    wr_ctl(8'h64);
    idle(200);
    chk(!irq && !scl_oe && !sda_oe, "R4 START held while busy", {irq, scl_oe, sda_oe}, 0);
    exp_q.push_back(8'h08);
    force_sda = 1'b0;
    wait_irq("R4 START after STOP");

    // arbitration loss on the first address bit
    wr_dat(8'hA0);
    force_sda = 1'b1;
    exp_q.push_back(8'h38);
    wr_ctl(8'h44);
    wait_irq("R10 irq after arbitration loss");
    idle(2);
    chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    force_sda = 1'b0;
    idle(20);
    wr_ctl(8'h44);
    chk(!irq, "R7 software clear", irq, 0);
    wr_ctl(8'h4C);
    idle(40);
    chk(!irq && ctl_rdata == 8'h44, "R7 writing 1 does not set flag", ctl_rdata, 8'h44);

    // disable while master
    exp_q.push_back(8'h08);
    wr_ctl(8'h64);
    wait_irq("R3 second START");
    wr_ctl(8'h34);
    idle(3);
    chk(ctl_rdata == 8'h24, "R2 STOP request cleared by disable", ctl_rdata, 8'h24);
    chk(stat_rdata == 8'hF8 && !irq, "R2 status idle when off", stat_rdata, 8'hF8);
    chk(!scl_oe && !sda_oe, "R2 lines released when off", {scl_oe, sda_oe}, 0);
    chk(irq == ctl_rdata[3], "R12 irq follows flag when off", irq, ctl_rdata[3]);

    chk(exp_q.size() == 0, "scoreboard drained R3 R5 R6 R8 R10", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule